// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host read and write a 32K x 8 asynchronous static RAM. The host raises a request with a 15-bit address, a direction flag and, for writes, a byte of data. It holds the request until a one-cycle acknowledge comes back. For reads, the returned byte is valid in the acknowledge cycle and stays valid until the next read finishes.

On the memory side the controller drives the address and three active-low strobes: select, output enable and write enable. The data bus is split into an outgoing byte, an incoming byte and a driver enable. Every phase of a memory cycle is stretched to a whole number of clock cycles. Each count is derived at elaboration time from a nanosecond minimum and the clock period.

Writes are controlled by the write strobe. The memory is selected one cycle before the write strobe falls and stays selected one cycle after it rises. The output enable stays high for the whole write, so the memory never drives the bus. The controller drives the bus only while the write strobe is low. A write that follows a read waits extra turnaround cycles, so the memory has released the bus before the controller drives it.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and immediately when reset is asserted in the middle of a cycle, mem_ce_n, mem_oe_n and mem_we_n are 1 and mem_dq_oe and host_ack are 0.
- R2: A read (host_we = 0) holds mem_ce_n and mem_oe_n at 0 and mem_we_n at 1 for exactly ACC_CYC cycles (3 at the default 4 ns clock), with mem_addr equal to the request address. host_rdata then shows the byte on mem_dq_in from the last of those cycles.
- R3: mem_we_n is 0 only while mem_ce_n is 0, and mem_oe_n stays 1 in every cycle of a write.
- R4: During a write, mem_we_n stays 0 for exactly WP_CYC cycles (3 at the default clock). mem_dq_oe is 1 in exactly those cycles, and mem_dq_out holds the request's write byte, unchanged, throughout.
- R5: mem_ce_n falls one cycle before mem_we_n falls and rises one cycle after mem_we_n rises. mem_addr does not change while mem_ce_n stays 0.
- R6: When requests are back to back, mem_dq_oe first rises 3 + TURN_CYC cycles after the acknowledge of a preceding read (TURN_CYC = 2 at the default clock), and 3 cycles after the acknowledge of a preceding write. mem_dq_oe is never 1 while mem_oe_n is 0.
- R7: A request is taken only when the controller is idle and not acknowledging. Changes on host_req, host_we and host_addr during a cycle do not affect the memory address or the direction of that cycle. A request held high through the acknowledge cycle is taken one cycle later.
- R8: host_ack is 1 for exactly one cycle per request. host_rdata keeps its last read value across writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Request address |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last byte read |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The memory is exercised with random mixes of reads and writes over the whole address range. Some operations are separated by idle gaps and some are back to back, and the gap between them separates the turnaround path from the plain path. Directed cases cover several patterns:
- The lowest and highest addresses.
- Read-after-write of the same byte, which shows that the write strobe really captured the data.
- Reads whose request inputs change mid-cycle, which shows that requests are ignored while busy.
- Reset asserted while the write strobe is low.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_RD    = 3'd2,
    ST_WSET  = 3'd3,
    ST_WPUL  = 3'd4,
    ST_WHOLD = 3'd5
  } seq_state_e;

  // whole clock cycles covering a nanosecond minimum, never below one
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ACC_CYC  = 3,
  parameter int WP_CYC   = 3,
  parameter int TURN_CYC = 2,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic             ack_busy,
  input  logic             tmr_expired,
  output logic             accept,
  output logic             finish_rd,
  output logic             finish_wr,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             mem_dq_oe
);

  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  seq_state_e st_q, st_d;
  logic       last_rd_q, last_rd_d, last_rd_en;
  logic       ce_d, oe_d, we_d, drv_d;

  // next-state process
  always_comb begin
    st_d      = st_q;
    accept    = 1'b0;
    finish_rd = 1'b0;
    finish_wr = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (st_q)
      ST_IDLE: begin
        if (host_req && !ack_busy) begin
          accept = 1'b1;
          if (host_we) begin
            if (last_rd_q) begin
              st_d     = ST_TURN;
              tmr_load = 1'b1;
              tmr_val  = TURN_LD;
            end else begin
              st_d = ST_WSET;
            end
          end else begin
            st_d     = ST_RD;
            tmr_load = 1'b1;
            tmr_val  = ACC_LD;
          end
        end
      end
      ST_TURN: if (tmr_expired) st_d = ST_WSET;
      ST_WSET: begin
        st_d     = ST_WPUL;
        tmr_load = 1'b1;
        tmr_val  = WP_LD;
      end
      ST_WPUL: if (tmr_expired) st_d = ST_WHOLD;
      ST_WHOLD: begin
        st_d      = ST_IDLE;
        finish_wr = 1'b1;
      end
      ST_RD: begin
        if (tmr_expired) begin
          st_d      = ST_IDLE;
          finish_rd = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // strobe decode of the next state, registered below
  always_comb begin
    ce_d       = (st_d == ST_RD) || (st_d == ST_WSET) ||
                 (st_d == ST_WPUL) || (st_d == ST_WHOLD);
    oe_d       = (st_d == ST_RD);
    we_d       = (st_d == ST_WPUL);
    drv_d      = (st_d == ST_WPUL);
    last_rd_en = finish_rd || finish_wr;
    last_rd_d  = finish_rd;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      st_q      <= st_d;
      mem_ce_n  <= !ce_d;
      mem_oe_n  <= !oe_d;
      mem_we_n  <= !we_d;
      mem_dq_oe <= drv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          last_rd_q <= 1'b0;
    else if (last_rd_en) last_rd_q <= last_rd_d;
  end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              finish_rd,
  input  logic              finish_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ack
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= host_addr;
      mem_dq_out <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         host_rdata <= '0;
    else if (finish_rd) host_rdata <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_ack <= 1'b0;
    else        host_ack <= finish_rd || finish_wr;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 4,
  parameter int ACC_NS  = 12,
  parameter int OEA_NS  = 6,
  parameter int CYC_NS  = 12,
  parameter int WP_NS   = 10,
  parameter int DS_NS   = 6,
  parameter int REL_NS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int ACC_CYC  = imax(imax(ns_to_cycles(ACC_NS, CLK_NS),
                                      ns_to_cycles(OEA_NS, CLK_NS)),
                                 ns_to_cycles(CYC_NS, CLK_NS));
  localparam int WP_CYC   = imax(ns_to_cycles(WP_NS, CLK_NS),
                                 ns_to_cycles(DS_NS, CLK_NS));
  localparam int TURN_CYC = ns_to_cycles(REL_NS, CLK_NS);
  localparam int MAX_CYC  = imax(imax(ACC_CYC, WP_CYC), TURN_CYC);
  localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             accept, finish_rd, finish_wr;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_seq_fsm #(
    .ACC_CYC  (ACC_CYC),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .ack_busy    (host_ack),
    .tmr_expired (tmr_expired),
    .accept      (accept),
    .finish_rd   (finish_rd),
    .finish_wr   (finish_wr),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dq_oe   (mem_dq_oe)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .finish_rd  (finish_rd),
    .finish_wr  (finish_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .host_rdata (host_rdata),
    .host_ack   (host_ack)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 3,
  parameter int WP_CYC  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  logic [7:0] wl_cnt, rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      if (mem_we_n)          wl_cnt <= '0;
      else if (wl_cnt != '1) wl_cnt <= wl_cnt + 8'd1;
      if (mem_oe_n)          rd_cnt <= '0;
      else if (rd_cnt != '1) rd_cnt <= rd_cnt + 8'd1;
    end
  end

  AST_WE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);  // R3
  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);  // R3
  AST_RD_ACCESS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (rd_cnt >= 8'(ACC_CYC)));  // R2
  AST_WPULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_cnt >= 8'(WP_CYC)));  // R4
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);  // R4
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));  // R4
  AST_CE_LEADS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n));  // R5
  AST_CE_TRAILS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);  // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));  // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);  // R6
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);  // R8

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .ACC_CYC (ACC_CYC),
  .WP_CYC  (WP_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ack   (host_ack),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;

  localparam int CLK_NS = 4;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_ACC  = mx(mx(cdiv(12), cdiv(6)), cdiv(12));
  localparam int EXP_WP   = mx(cdiv(10), cdiv(6));
  localparam int EXP_TURN = cdiv(6);

  logic        clk, rst_n;
  logic        host_req, host_we, host_ack;
  logic [14:0] host_addr, mem_addr;
  logic [7:0]  host_wdata, host_rdata, mem_dq_out, mem_dq_in;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

  sram_async_ctrl #(.CLK_NS(CLK_NS)) uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model: drives only when selected, output-enabled and not writing
  logic [7:0] model_mem [256];
  logic [7:0] exp_mem   [256];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model_mem[mem_addr[7:0]] : 8'h00;

  function automatic logic [7:0] init_pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) model_mem[i] <= init_pat(i);
    end else if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      model_mem[mem_addr[7:0]] <= mem_dq_out;
    end
  end

  int n_chk, n_err;
  bit chained;
  bit last_was_rd;
  int last_end;
  logic [7:0] last_rdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reset_exp();
    for (int i = 0; i < 256; i++) exp_mem[i] = init_pat(i);
    last_rdata = 8'h00;
    chained = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    chained = 1'b0;
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    int wl = 0, first_dq = -1, n = 0, ackcyc = 0;
    bit done = 0, abad = 0, dbad = 0, oebad = 0;
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
      if (n == 1) chk(!host_ack, "R8 ack one cycle", host_ack, 0);
      else if (host_ack) begin done = 1; ackcyc = cyc; end
      if (!mem_we_n) wl++;
      if (mem_dq_oe && first_dq < 0) first_dq = cyc;
      if (!mem_ce_n && mem_addr !== a) abad = 1;
      if (mem_dq_oe && mem_dq_out !== d) dbad = 1;
      if (!mem_ce_n && !mem_oe_n) oebad = 1;
    end
    host_req = 1'b0;
    chk(done, "R8 write ack", done, 1);
    chk(wl == EXP_WP, "R4 write pulse length", wl, EXP_WP);
    chk(!dbad, "R4 write data on bus", dbad, 0);
    chk(!abad, "R5 write address", abad, 0);
    chk(!oebad, "R3 oe high in write", oebad, 0);
    chk(host_rdata == last_rdata, "R8 rdata held over write", host_rdata, last_rdata);
    if (chained) begin
      int eg = last_was_rd ? 3 + EXP_TURN : 3;
      chk(first_dq - last_end == eg, "R6 drive gap", first_dq - last_end, eg);
    end
    exp_mem[a[7:0]] = d;
    last_was_rd = 1'b0;
    last_end = ackcyc;
    chained = 1'b1;
  endtask

  task automatic do_read(input logic [14:0] a, input bit disturb);
    int ol = 0, n = 0, ackcyc = 0;
    bit done = 0, abad = 0, webad = 0;
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
      if (n == 1) chk(!host_ack, "R8 ack one cycle", host_ack, 0);
      else if (host_ack) begin done = 1; ackcyc = cyc; end
      if (!mem_oe_n) ol++;
      if (!mem_ce_n && mem_addr !== a) abad = 1;
      if (!mem_we_n || mem_dq_oe) webad = 1;
      if (disturb && !mem_ce_n) begin
        host_addr = ~a;
        host_we = 1'b1;
      end
    end
    host_req = 1'b0;
    chk(done, "R8 read ack", done, 1);
    chk(ol == EXP_ACC, "R2 read access length", ol, EXP_ACC);
    chk(host_rdata == exp_mem[a[7:0]], "R2 read data", host_rdata, exp_mem[a[7:0]]);
    chk(!webad, "R2 no write strobe in read", webad, 0);
    if (disturb) chk(!abad, "R7 address ignored while busy", abad, 0);
    else         chk(!abad, "R5 read address", abad, 0);
    last_rdata = host_rdata;
    last_was_rd = 1'b1;
    last_end = ackcyc;
    chained = 1'b1;
  endtask

  task automatic chk_idle_pins(input string req);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_ack, req,
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, host_ack}, 5'b11100);
  endtask

  initial begin
    #(200000 * CLK_NS);
    n_err++;
    $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cyc = 0; n_chk = 0; n_err = 0;
    host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    last_end = 0; last_was_rd = 0;
    rst_n = 1'b0;
    reset_exp();
    repeat (3) @(negedge clk);
    chk_idle_pins("R1 pins in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle_pins("R1 pins after reset");
    chk(host_rdata == 8'h00, "R1 rdata after reset", host_rdata, 0);

    // R1: reset in the middle of a write pulse
    host_req = 1'b1; host_we = 1'b1; host_addr = 15'h0042; host_wdata = 8'hA5;
    for (int i = 0; i < 10 && mem_we_n; i++) @(negedge clk);
    chk(!mem_we_n, "R4 pulse reached before reset", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk_idle_pins("R1 pins on reset mid write");
    host_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reset_exp();

    // directed corners
    do_write(15'h0000, 8'h3C);
    do_write(15'h7FFF, 8'hC3);
    do_read(15'h0000, 1'b0);
    do_read(15'h7FFF, 1'b0);
    do_write(15'h1234, 8'h5A);
    do_read(15'h1234, 1'b1);
    do_write(15'h2222, 8'h81);
    do_write(15'h2223, 8'h18);
    do_read(15'h2222, 1'b0);
    do_read(15'h2223, 1'b1);
    idle(4);
    do_write(15'h0100, 8'hFF);
    idle(2);
    do_read(15'h0100, 1'b0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [14:0] a;
      a = 15'($urandom);
      if (($urandom % 8) == 0) idle(int'($urandom % 4) + 1);
      if ($urandom % 2) do_write(a, 8'($urandom));
      else              do_read(a, ($urandom % 6) == 0);
    end
    idle(3);
    chk_idle_pins("R1 idle at end");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule